// File: doc/BRIEF.md
# PCI-X Master Transaction Terminator

This block decides how a PCI-X bus master ends each transaction it starts. An upstream sequencer presents a request: its kind, the offset of its start address inside a 128-byte window, and its byte count. The block drives the address phase. It then waits up to a fixed number of clocks for a target to claim the cycle with DEVSEL#. After that it runs data phases while the target signals ready, counting down the bytes and tracking how far the next allowable disconnect boundary (ADB) lies.

A transaction ends in one of three ways. If no target claims it in time, it ends in a master abort. If its byte count is used up, it ends normally. If a disconnect condition was seen for a kind that permits one, it ends by initiator disconnect at the next ADB. The disconnect conditions are an empty data buffer on a split completion, or an expired latency timer while the grant is withdrawn. Writes always run to their full count. A master abort on a special cycle that was translated from a configuration cycle counts as the expected outcome.

The block pulses a done flag with the cause of the ending. For kinds that expect an answer upstream, it also gives a completion with its status. It keeps a sticky received-master-abort bit that is cleared by a write-one-to-clear pulse.

Top module: `pxm_term_ctrl`

## Requirements
- R1: After reset, frame_n_o and irdy_n_o are 1, and busy_o, done_o, cpl_valid_o, cpl_mabort_o and rma_status_o are 0.
- R2: A start_i sampled while idle causes one address-phase clock with frame_n_o=0 and irdy_n_o=1. From then until termination, irdy_n_o is 0 and busy_o is 1. A start_i sampled while busy has no effect.
- R3: After the address phase, devsel_n_i is sampled on each of the next DEVSEL_TMO clocks (default 6). If it is sampled low on any of them, data phases begin on the next clock. If none sees it low, then on the next clock frame_n_o and irdy_n_o return to 1 and done_o pulses with cause_o=2. The cause encoding is 0 count satisfied, 1 initiator disconnect, 2 master abort.
- R4: rma_status_o becomes 1 on the clock after a master abort of any kind except 6. It then stays 1 until a clock on which rma_clr_i is sampled high with no new master abort. A new master abort wins over a clear.
- R5: Kinds are encoded as 0 memory read, 1 I/O read, 2 configuration read, 3 posted memory write, 4 delayed write, 5 split completion, 6 translated special cycle. For kinds 0, 1, 2, 4 and 6, cpl_valid_o pulses together with done_o. For kinds 3 and 5 it never pulses. cpl_mabort_o is 1 only with cpl_valid_o, only after a master abort, and never for kind 6.
- R6: Each data-phase clock with trdy_n_i=0 moves BUS_BYTES bytes (default 8), or what remains if that is less. frame_n_o is 1 during the data phase that satisfies the byte count. On the clock after that phase completes, done_o pulses with cause 0.
- R7: For kinds 3, 4 and 6, buf_empty_i, lat_expired_i and gnt_n_i have no effect on when the transaction ends.
- R8: For kind 5, a clock in the claim-wait or data state that samples buf_empty_i=1 arms a disconnect. From the next clock on, frame_n_o is 1 on the data phase whose offset is the last BUS_BYTES before a 128-byte boundary, and done_o follows with cause 1. For other kinds, buf_empty_i is ignored.
- R9: For kinds 0, 1, 2 and 5, lat_expired_i=1 sampled together with gnt_n_i=1 arms the same boundary disconnect as R8. lat_expired_i sampled with gnt_n_i=0 has no effect.
- R10: If the byte count runs out before the next boundary, the transaction ends with cause 0 at that data phase, even with a disconnect armed.
- R11: A data-phase clock with trdy_n_i=1 moves no data and keeps irdy_n_o at 0. Once frame_n_o has gone to 1 in the data state, it stays 1 until the final transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction (accepted when idle) |
| kind_i | input | 3 | Transaction kind (encoding in R5) |
| start_off_i | input | $clog2(ADB_BYTES) | Start address offset inside the boundary window, aligned to BUS_BYTES |
| byte_cnt_i | input | BC_W | Byte count, nonzero |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| gnt_n_i | input | 1 | Bus grant, active low |
| lat_expired_i | input | 1 | Master latency timer has expired |
| buf_empty_i | input | 1 | Outgoing data buffer has run dry |
| rma_clr_i | input | 1 | Write-one-to-clear pulse for the abort status bit |
| frame_n_o | output | 1 | FRAME# drive, active low |
| irdy_n_o | output | 1 | IRDY# drive, active low |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-clock pulse when a transaction ends |
| cause_o | output | 2 | Ending cause, valid with done_o |
| cpl_valid_o | output | 1 | Upstream completion pulse |
| cpl_mabort_o | output | 1 | Completion carries master-abort status |
| rma_status_o | output | 1 | Sticky received-master-abort bit |

## Verification
The hardest case to reach is a boundary disconnect that is armed late. Either the armed request lands on the very beat that sits just below the boundary, or the final phase before the boundary is stalled. Whether the frame rises there or one window later depends on single-clock timing. The stimulus places start offsets a few beats short of the boundary, including the last slot before it. It raises the buffer-empty and latency conditions from a chosen clock and mixes in periodic target stalls. A behavioural model in the bench then decides, clock by clock, where the frame must rise.

// File: rtl/pxm_term_pkg.sv
package pxm_term_pkg;

   typedef enum logic [2:0] {
      K_MEM_RD    = 3'd0,
      K_IO_RD     = 3'd1,
      K_CFG_RD    = 3'd2,
      K_MEM_WR    = 3'd3,
      K_DLY_WR    = 3'd4,
      K_SPLIT_CPL = 3'd5,
      K_SPECIAL   = 3'd6,
      K_RSVD      = 3'd7
   } pxm_kind_e;

   typedef enum logic [1:0] {
      END_DONE   = 2'd0,
      END_DISC   = 2'd1,
      END_MABORT = 2'd2
   } pxm_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_DATA = 2'd3
   } pxm_state_e;

   // writes always run to their full byte count
   function automatic logic kind_is_write(pxm_kind_e k);
      return (k == K_MEM_WR) || (k == K_DLY_WR) || (k == K_SPECIAL);
   endfunction

   // kinds whose requester waits for a completion upstream
   function automatic logic kind_reports(pxm_kind_e k);
      return (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_CFG_RD) ||
             (k == K_DLY_WR) || (k == K_SPECIAL);
   endfunction

   // only split completions drain a buffer that can run dry
   function automatic logic kind_drains_buffer(pxm_kind_e k);
      return k == K_SPLIT_CPL;
   endfunction

   // master abort is the expected outcome for a translated special cycle
   function automatic logic kind_abort_expected(pxm_kind_e k);
      return k == K_SPECIAL;
   endfunction

endpackage

// File: rtl/pxm_devsel_timer.sv
module pxm_devsel_timer #(
   parameter int TMO = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic run_i,
   input  logic devsel_n_i,
   output logic claim_o,
   output logic expire_o
);
   localparam int CW = $clog2(TMO + 1);

   generate
      if (TMO < 1) begin : g_bad_tmo
         $error("pxm_devsel_timer: TMO must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm_i) begin
         cnt_q <= CW'(1);
      end else if (run_i && devsel_n_i && (cnt_q != CW'(TMO))) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign claim_o  = run_i & ~devsel_n_i;
   assign expire_o = run_i & devsel_n_i & (cnt_q == CW'(TMO));

   AST_WAIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) run_i |-> (cnt_q != '0) && (cnt_q <= CW'(TMO))) else $error("claim wait outside window"); // R3
   AST_CLAIM_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (run_i && !devsel_n_i) |=> !run_i) else $error("claim did not leave wait"); // R3

endmodule

// File: rtl/pxm_adb_tracker.sv
module pxm_adb_tracker #(
   parameter int BC_W      = 12,
   parameter int BUS_BYTES = 8,
   parameter int ADB_BYTES = 128
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [$clog2(ADB_BYTES)-1:0] load_off_i,
   input  logic [BC_W-1:0]              load_cnt_i,
   input  logic                         beat_i,
   input  logic                         disc_req_i,
   output logic                         last_o,
   output logic                         count_met_o
);
   localparam int OW     = $clog2(ADB_BYTES);
   localparam int OW1    = OW + 1;
   localparam int BUS_LG = $clog2(BUS_BYTES);

   generate
      if ((BUS_BYTES < 2) || ((BUS_BYTES & (BUS_BYTES - 1)) != 0)) begin : g_bad_bus
         $error("pxm_adb_tracker: BUS_BYTES must be a power of two >= 2");
      end
      if ((ADB_BYTES < BUS_BYTES) || ((ADB_BYTES & (ADB_BYTES - 1)) != 0)) begin : g_bad_adb
         $error("pxm_adb_tracker: ADB_BYTES must be a power of two >= BUS_BYTES");
      end
      if (BC_W <= BUS_LG) begin : g_bad_bc
         $error("pxm_adb_tracker: BC_W too narrow for one beat");
      end
   endgenerate

   logic [BC_W-1:0] rem_q;
   logic [OW-1:0]   off_q;
   logic            disc_q;
   logic            at_adb;

   assign count_met_o = rem_q <= BC_W'(BUS_BYTES);

   generate
      if (ADB_BYTES == BUS_BYTES) begin : g_every_beat
         assign at_adb = 1'b1;
      end else begin : g_window
         assign at_adb = ({1'b0, off_q} + OW1'(BUS_BYTES)) >= OW1'(ADB_BYTES);
      end
   endgenerate

   assign last_o = count_met_o | (disc_q & at_adb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         off_q  <= '0;
         disc_q <= 1'b0;
      end else if (load_i) begin
         rem_q  <= load_cnt_i;
         off_q  <= load_off_i;
         disc_q <= 1'b0;
      end else begin
         if (beat_i) begin
            rem_q <= count_met_o ? '0 : rem_q - BC_W'(BUS_BYTES);
            off_q <= off_q + OW'(BUS_BYTES);
         end
         if (disc_req_i) begin
            disc_q <= 1'b1;
         end
      end
   end

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) load_i |-> (load_cnt_i != '0)) else $error("zero byte count"); // R6
   AST_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) load_i |-> (load_off_i[BUS_LG-1:0] == '0)) else $error("unaligned start"); // R8
   AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (last_o && !beat_i && !load_i) |=> last_o) else $error("final phase withdrawn"); // R11

endmodule

// File: rtl/pxm_term_fsm.sv
module pxm_term_fsm
   import pxm_term_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       claim_i,
   input  logic       expire_i,
   input  logic       trdy_n_i,
   input  logic       last_i,
   input  logic       count_met_i,
   output pxm_state_e state_o,
   output logic       load_o,
   output logic       arm_o,
   output logic       run_o,
   output logic       beat_o,
   output logic       fin_o,
   output pxm_cause_e fin_cause_o,
   output logic       frame_n_o,
   output logic       irdy_n_o
);
   pxm_state_e st_q, st_d;

   assign load_o = (st_q == ST_IDLE) & start_i;
   assign arm_o  = (st_q == ST_ADDR);
   assign run_o  = (st_q == ST_WAIT);
   assign beat_o = (st_q == ST_DATA) & ~trdy_n_i;
   assign fin_o  = expire_i | (beat_o & last_i);

   always_comb begin
      if (expire_i)         fin_cause_o = END_MABORT;
      else if (count_met_i) fin_cause_o = END_DONE;
      else                  fin_cause_o = END_DISC;
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start_i) st_d = ST_ADDR;
         ST_ADDR: st_d = ST_WAIT;
         ST_WAIT: begin
            if (claim_i)       st_d = ST_DATA;
            else if (expire_i) st_d = ST_IDLE;
         end
         ST_DATA: if (fin_o) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o   = st_q;
   assign frame_n_o = ~((st_q == ST_ADDR) | (st_q == ST_WAIT) | ((st_q == ST_DATA) & ~last_i));
   assign irdy_n_o  = ~((st_q == ST_WAIT) | (st_q == ST_DATA));

   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) expire_i |=> (frame_n_o && irdy_n_o)) else $error("bus held after abort"); // R3
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ((st_q == ST_DATA) && frame_n_o && trdy_n_i) |=> (frame_n_o && !irdy_n_o)) else $error("stall dropped final phase"); // R11
   AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n) load_o |=> (!frame_n_o && irdy_n_o)) else $error("address phase wrong"); // R2

endmodule

// File: rtl/pxm_term_ctrl.sv
module pxm_term_ctrl
   import pxm_term_pkg::*;
#(
   parameter int BC_W       = 12,
   parameter int BUS_BYTES  = 8,
   parameter int ADB_BYTES  = 128,
   parameter int DEVSEL_TMO = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [2:0]                   kind_i,
   input  logic [$clog2(ADB_BYTES)-1:0] start_off_i,
   input  logic [BC_W-1:0]              byte_cnt_i,
   input  logic                         devsel_n_i,
   input  logic                         trdy_n_i,
   input  logic                         gnt_n_i,
   input  logic                         lat_expired_i,
   input  logic                         buf_empty_i,
   input  logic                         rma_clr_i,
   output logic                         frame_n_o,
   output logic                         irdy_n_o,
   output logic                         busy_o,
   output logic                         done_o,
   output logic [1:0]                   cause_o,
   output logic                         cpl_valid_o,
   output logic                         cpl_mabort_o,
   output logic                         rma_status_o
);
   pxm_state_e st;
   pxm_cause_e fin_cause;
   pxm_kind_e  kind_q;
   logic load, arm, run, beat, fin, claim, expire, last, count_met, disc_req;
   logic done_q, cpl_valid_q, cpl_ma_q, rma_q;
   pxm_cause_e cause_q;
   logic abort_now, rma_set;

   pxm_devsel_timer #(.TMO(DEVSEL_TMO)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm),
      .run_i      (run),
      .devsel_n_i (devsel_n_i),
      .claim_o    (claim),
      .expire_o   (expire)
   );

   pxm_adb_tracker #(.BC_W(BC_W), .BUS_BYTES(BUS_BYTES), .ADB_BYTES(ADB_BYTES)) u_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .load_off_i  (start_off_i),
      .load_cnt_i  (byte_cnt_i),
      .beat_i      (beat),
      .disc_req_i  (disc_req),
      .last_o      (last),
      .count_met_o (count_met)
   );

   pxm_term_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .claim_i     (claim),
      .expire_i    (expire),
      .trdy_n_i    (trdy_n_i),
      .last_i      (last),
      .count_met_i (count_met),
      .state_o     (st),
      .load_o      (load),
      .arm_o       (arm),
      .run_o       (run),
      .beat_o      (beat),
      .fin_o       (fin),
      .fin_cause_o (fin_cause),
      .frame_n_o   (frame_n_o),
      .irdy_n_o    (irdy_n_o)
   );

   // disconnect requests are only honoured for kinds that may stop early
   assign disc_req = ((st == ST_WAIT) | (st == ST_DATA)) & ~kind_is_write(kind_q) &
                     ((kind_drains_buffer(kind_q) & buf_empty_i) | (lat_expired_i & gnt_n_i));

   assign abort_now = fin & (fin_cause == END_MABORT);
   assign rma_set   = abort_now & ~kind_abort_expected(kind_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q      <= K_MEM_RD;
         done_q      <= 1'b0;
         cause_q     <= END_DONE;
         cpl_valid_q <= 1'b0;
         cpl_ma_q    <= 1'b0;
         rma_q       <= 1'b0;
      end else begin
         if (load) kind_q <= pxm_kind_e'(kind_i);
         done_q      <= fin;
         cpl_valid_q <= fin & kind_reports(kind_q);
         cpl_ma_q    <= rma_set & kind_reports(kind_q);
         if (fin) cause_q <= fin_cause;
         if (rma_set)        rma_q <= 1'b1;
         else if (rma_clr_i) rma_q <= 1'b0;
      end
   end

   assign busy_o       = (st != ST_IDLE);
   assign done_o       = done_q;
   assign cause_o      = cause_q;
   assign cpl_valid_o  = cpl_valid_q;
   assign cpl_mabort_o = cpl_ma_q;
   assign rma_status_o = rma_q;

   AST_RMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rma_q && !rma_clr_i) |=> rma_q) else $error("abort status lost"); // R4
   AST_CPL_AT_END: assert property (@(posedge clk) disable iff (!rst_n) cpl_valid_o |-> done_o) else $error("completion without end"); // R5
   AST_CPL_MA_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) cpl_mabort_o |-> (cpl_valid_o && cause_o == END_MABORT)) else $error("abort status without abort"); // R5
   AST_WRITE_NO_DISC: assert property (@(posedge clk) disable iff (!rst_n) (done_o && cause_o == END_DISC) |-> !kind_is_write(kind_q)) else $error("write disconnected early"); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (frame_n_o && irdy_n_o)) else $error("bus driven while idle"); // R1

endmodule

// File: tb/pxm_term_ctrl_bench.sv
module pxm_term_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] kind_i = 3'd0;
   logic [6:0] start_off_i = 7'd0;
   logic [11:0] byte_cnt_i = 12'd8;
   logic devsel_n_i = 1'b1, trdy_n_i = 1'b1, gnt_n_i = 1'b0;
   logic lat_expired_i = 1'b0, buf_empty_i = 1'b0, rma_clr_i = 1'b0;
   logic frame_n_o, irdy_n_o, busy_o, done_o, cpl_valid_o, cpl_mabort_o, rma_status_o;
   logic [1:0] cause_o;

   int checks = 0, errors = 0, cycles = 0;
   bit finished = 1'b0;
   int last_cause, last_cplv, last_cplma;

   always #4 clk = ~clk;

   pxm_term_ctrl u_pxm_term_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
      .start_off_i(start_off_i), .byte_cnt_i(byte_cnt_i), .devsel_n_i(devsel_n_i),
      .trdy_n_i(trdy_n_i), .gnt_n_i(gnt_n_i), .lat_expired_i(lat_expired_i),
      .buf_empty_i(buf_empty_i), .rma_clr_i(rma_clr_i), .frame_n_o(frame_n_o),
      .irdy_n_o(irdy_n_o), .busy_o(busy_o), .done_o(done_o), .cause_o(cause_o),
      .cpl_valid_o(cpl_valid_o), .cpl_mabort_o(cpl_mabort_o), .rma_status_o(rma_status_o)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   int m_st = 0, m_cnt = 0, m_rem = 0, m_off = 0, m_kind = 0, m_cause = 0;
   bit m_disc = 0, m_done = 0, m_cplv = 0, m_cplma = 0, m_rma = 0;

   function automatic bit m_last();
      return (m_rem <= 8) || (m_disc && (m_off % 128) == 120);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_rem = 0; m_off = 0; m_kind = 0; m_cause = 0;
         m_disc = 0; m_done = 0; m_cplv = 0; m_cplma = 0; m_rma = 0;
      end else begin
         bit fin, last, iswr, cond, rep;
         int fc;
         fin = 0; fc = 0; last = m_last();
         iswr = (m_kind == 3) || (m_kind == 4) || (m_kind == 6);
         cond = !iswr && ((m_kind == 5 && buf_empty_i) || (lat_expired_i && gnt_n_i));
         m_done = 0; m_cplv = 0; m_cplma = 0;
         case (m_st)
            0: if (start_i) begin
                  m_kind = kind_i; m_rem = byte_cnt_i; m_off = start_off_i; m_disc = 0; m_st = 1;
               end
            1: begin m_st = 2; m_cnt = 1; end
            2: begin
                  if (cond) m_disc = 1;
                  if (!devsel_n_i) m_st = 3;
                  else if (m_cnt == 6) begin fin = 1; fc = 2; end
                  else m_cnt++;
               end
            default: begin
                  if (!trdy_n_i) begin
                     if (last) begin fin = 1; fc = (m_rem <= 8) ? 0 : 1; end
                     else begin m_rem -= 8; m_off = (m_off + 8) % 128; end
                  end
                  if (cond) m_disc = 1;
               end
         endcase
         rep = (m_kind != 3) && (m_kind != 5);
         if (fin) begin
            m_st = 0; m_done = 1; m_cause = fc; m_cplv = rep;
            m_cplma = rep && fc == 2 && m_kind != 6;
         end
         if (fin && fc == 2 && m_kind != 6) m_rma = 1;
         else if (rma_clr_i) m_rma = 0;
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R6 frame_n", frame_n_o, (m_st == 0) ? 1 : (m_st == 3) ? int'(m_last()) : 0);
         check("R2 irdy_n", irdy_n_o, (m_st <= 1) ? 1 : 0);
         check("R2 busy", busy_o, (m_st != 0) ? 1 : 0);
         check("R3 done", done_o, m_done);
         if (m_done) check("R3 cause", cause_o, m_cause);
         check("R5 cpl_valid", cpl_valid_o, m_cplv);
         check("R5 cpl_mabort", cpl_mabort_o, m_cplma);
         check("R4 rma", rma_status_o, m_rma);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   // dev_dly: claim-wait clock (1..6) on which DEVSEL# is seen; 7 = never
   // dmode: 1 buffer empty, 2 latency expired with grant removed, 3 latency expired with grant held
   task automatic run_xact(int kind, int off, int bc, int dev_dly, int stall_mod, int dmode, int dfrom);
      int cyc;
      @(negedge clk);
      start_i = 1; kind_i = 3'(kind); start_off_i = 7'(off); byte_cnt_i = 12'(bc);
      cyc = 0;
      forever begin
         @(negedge clk);
         start_i = 0;
         cyc++;
         if (done_o) begin
            last_cause = cause_o; last_cplv = cpl_valid_o; last_cplma = cpl_mabort_o;
            break;
         end
         if (cyc > 3000) begin
            errors++;
            $display("FAIL transaction never ended");
            break;
         end
         devsel_n_i = !(dev_dly <= 6 && cyc >= dev_dly + 1);
         trdy_n_i = (stall_mod != 0) && (cyc % stall_mod == 0);
         if (cyc >= dfrom) begin
            buf_empty_i = (dmode == 1);
            lat_expired_i = (dmode == 2) || (dmode == 3);
            gnt_n_i = (dmode == 2);
         end
      end
      devsel_n_i = 1; trdy_n_i = 1; buf_empty_i = 0; lat_expired_i = 0; gnt_n_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 frame_n reset", frame_n_o, 1);
      check("R1 irdy_n reset", irdy_n_o, 1);
      check("R1 busy reset", busy_o, 0);
      check("R1 rma reset", rma_status_o, 0);
      check("R1 cpl reset", cpl_valid_o, 0);
      rst_n = 1;

      run_xact(0, 0, 32, 1, 0, 0, 0);
      check("R6 mem read count", last_cause, 0);
      check("R5 read completion", last_cplv, 1);

      run_xact(0, 0, 8, 6, 0, 0, 0);
      check("R3 claim on last window clock", last_cause, 0);

      run_xact(0, 0, 8, 7, 0, 0, 0);
      check("R3 no claim aborts", last_cause, 2);
      check("R5 abort status", last_cplma, 1);
      check("R4 abort sets status", rma_status_o, 1);

      run_xact(3, 0, 16, 2, 0, 0, 0);
      check("R4 status persists", rma_status_o, 1);
      check("R5 posted write silent", last_cplv, 0);

      @(negedge clk); rma_clr_i = 1;
      @(negedge clk); rma_clr_i = 0;
      check("R4 clear", rma_status_o, 0);

      run_xact(6, 0, 8, 7, 0, 0, 0);
      check("R3 special abort cause", last_cause, 2);
      check("R4 special leaves status", rma_status_o, 0);
      check("R5 special normal completion", last_cplma, 0);

      run_xact(3, 64, 256, 1, 0, 2, 1);
      check("R7 posted write runs full count", last_cause, 0);
      run_xact(4, 120, 32, 1, 0, 2, 1);
      check("R7 delayed write runs full count", last_cause, 0);

      run_xact(5, 64, 256, 1, 0, 1, 1);
      check("R8 split buffer empty disconnect", last_cause, 1);
      run_xact(5, 120, 64, 2, 4, 1, 1);
      check("R8 disconnect at immediate boundary", last_cause, 1);
      run_xact(0, 0, 256, 1, 0, 1, 1);
      check("R8 buffer empty ignored on read", last_cause, 0);
      run_xact(5, 0, 200, 1, 3, 1, 12);
      check("R8 late empty with stalls", last_cause, 1);

      run_xact(2, 0, 256, 1, 0, 2, 1);
      check("R9 latency with grant removed", last_cause, 1);
      run_xact(1, 0, 64, 1, 0, 3, 1);
      check("R9 latency with grant held", last_cause, 0);

      run_xact(0, 96, 16, 1, 0, 2, 1);
      check("R10 count ends before boundary", last_cause, 0);

      run_xact(1, 8, 40, 3, 3, 0, 0);
      check("R11 stalled read completes", last_cause, 0);
      run_xact(5, 104, 96, 1, 2, 1, 4);
      check("R11 stall on boundary phase", last_cause, 1);

      run_xact(4, 0, 4, 7, 0, 0, 0);
      check("R5 delayed write abort completion", last_cplma, 1);
      run_xact(3, 0, 8, 7, 0, 0, 0);
      check("R5 posted write abort no completion", last_cplv, 0);
      check("R4 posted write abort sets status", rma_status_o, 1);

      @(negedge clk); start_i = 1; kind_i = 0; start_off_i = 0; byte_cnt_i = 16;
      @(negedge clk); start_i = 1; byte_cnt_i = 64;
      @(negedge clk); start_i = 0; devsel_n_i = 0; trdy_n_i = 0;
      repeat (6) @(negedge clk);
      check("R2 start while busy ignored", busy_o, 0);
      devsel_n_i = 1; trdy_n_i = 1;

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule